// File: doc/BRIEF.md
# Self-Triggered Segment Capture Buffer

This block is the digital core of a sampler that runs with no dead time. A sample stream arrives continuously. A self-trigger pulse opens a capture, and the block stores a fixed-length segment of samples into the next free slot of a small circular store. In the trigger cycle it also records the value of a free-running coarse counter as that segment's timestamp. While later segments are being captured, a separate read side streams finished segments out word by word, in capture order, and each word carries its segment's timestamp.

Separate write and read pointers, each with an extra wrap bit, track the slots. Equal pointers mean empty. Pointers that agree in the slot bits but differ in the wrap bit mean full. A data-available flag lets the downstream reader run on demand. A trigger that finds every slot holding an unread segment is discarded and sets a sticky overflow flag. A trigger that arrives while a capture is already in progress has no effect.

The input stream has no back-pressure. A sample is taken in every cycle where `smp_valid` is high, and there is no ready signal on that side. The output stream is valid/ready. A word transfers on a cycle where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the word, its timestamp and its last marker stay unchanged.

Top module: `seg_capture`

## Requirements
- R1: After reset, `out_valid`, `data_avail` and `overflow` are all 0.
- R2: An accepted trigger captures SEG_LEN (default 32) samples. The first is the sample presented with `smp_valid` high in the trigger cycle itself. The rest are the following cycles in which `smp_valid` is high. Cycles with `smp_valid` low are skipped.
- R3: The timestamp of a segment is the coarse counter value in its trigger cycle. The counter is 0 in the first cycle after reset is released, increments by 1 every clock, and wraps modulo 2^TS_W.
- R4: A trigger that arrives while a capture is in progress is ignored and does not set `overflow`. A trigger in the cycle right after a segment's last sample starts a new capture.
- R5: A trigger that arrives while NUM_SLOTS (default 4) finished segments are unread is dropped. It sets `overflow`, which stays at 1 until reset. No segment from the dropped trigger is ever read out.
- R6: `data_avail` is 1 exactly when at least one finished segment is unread. It rises in the cycle after the clock edge that stores a segment's last sample.
- R7: Each segment is delivered as SEG_LEN words in capture order. `out_last` is 1 on the final word only, and `out_ts` carries the segment's timestamp on every word.
- R8: Segments come out in the order they were triggered, and reading may overlap with capture of later segments.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_data`, `out_ts` and `out_last` hold their values, and no word is lost or repeated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the coarse counter advances on every rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_valid | input | 1 | A sample is present on `smp_data` this cycle |
| smp_data | input | SAMPLE_W | Sample value |
| trig | input | 1 | Self-trigger request, sampled every cycle |
| out_ready | input | 1 | Downstream accepts the current output word |
| out_valid | output | 1 | An output word is offered |
| out_data | output | SAMPLE_W | Output sample word |
| out_ts | output | TS_W | Timestamp of the segment being read |
| out_last | output | 1 | Final word of the segment |
| data_avail | output | 1 | At least one finished segment is unread |
| overflow | output | 1 | Sticky: a trigger was dropped because all slots were full |

## Verification
The bench fills every slot while the reader is stalled, and then fires one more trigger. A design that compared only the slot bits of the pointers would take the full buffer for empty and either lose all four segments or overwrite the oldest one. A second trigger is placed in the middle of a capture, and another lands in the very cycle after a last sample. A design that restarts captures would emit a shortened segment for the first, and one that holds a busy flag a cycle too long would drop the second. Readout is throttled to every other cycle while new segments are written. This exposes any pointer or index that advances without a handshake, or any word taken from the wrong slot. Timestamps are checked across the counter's wrap, so an off-by-one in the cycle at which the counter is latched shows on every segment.

// File: rtl/seg_capture_pkg.sv
package seg_capture_pkg;

  // Capture side sequencing
  typedef enum logic [0:0] {
    WR_IDLE = 1'b0,
    WR_FILL = 1'b1
  } wr_state_e;

endpackage

// File: rtl/seg_coarse_ctr.sv
module seg_coarse_ctr #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);

  // Free-running coarse time base; wraps naturally at 2^TS_W
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + TS_W'(1);
  end

endmodule

// File: rtl/seg_wr_ctrl.sv
module seg_wr_ctrl
  import seg_capture_pkg::*;
#(
  parameter int SEG_LEN   = 32,
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = $clog2(SEG_LEN),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int PTR_W    = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig,
  input  logic              smp_valid,
  input  logic [PTR_W-1:0]  rptr,
  output logic [PTR_W-1:0]  wptr,
  output logic              we,
  output logic [SLOT_W-1:0] w_slot,
  output logic [IDX_W-1:0]  w_idx,
  output logic              ts_we,
  output logic              overflow
);

  wr_state_e        st;
  logic [IDX_W-1:0] widx;
  logic             full;
  logic             accept;
  logic             seg_done;

  // Full: same slot, opposite lap
  assign full = (wptr[PTR_W-1] != rptr[PTR_W-1]) &&
                (wptr[SLOT_W-1:0] == rptr[SLOT_W-1:0]);

  assign accept   = (st == WR_IDLE) && trig && !full;
  assign we       = smp_valid && (accept || (st == WR_FILL));
  assign w_idx    = accept ? '0 : widx;
  assign seg_done = we && (w_idx == IDX_W'(SEG_LEN - 1));
  assign w_slot   = wptr[SLOT_W-1:0];
  assign ts_we    = accept;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= WR_IDLE;
      widx <= '0;
      wptr <= '0;
    end else begin
      if (accept) st <= WR_FILL;
      if (we)     widx <= w_idx + IDX_W'(1);
      if (seg_done) begin
        st   <= WR_IDLE;
        widx <= '0;
        wptr <= wptr + PTR_W'(1);
      end
    end
  end

  // Sticky drop indication; triggers during a capture never reach here
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             overflow <= 1'b0;
    else if ((st == WR_IDLE) && trig && full) overflow <= 1'b1;
  end

  // R5: once set, the drop flag stays set
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  // R5: the flag only rises after a trigger met a full buffer
  a_r5_ovf_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(trig && full));

  // R2: a segment is committed one at a time
  a_r2_wptr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (wptr != $past(wptr)) |-> (wptr == $past(wptr) + PTR_W'(1)));

endmodule

// File: rtl/seg_store.sv
module seg_store #(
  parameter int SAMPLE_W  = 12,
  parameter int TS_W      = 16,
  parameter int SEG_LEN   = 32,
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = $clog2(SEG_LEN),
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [SLOT_W-1:0]   w_slot,
  input  logic [IDX_W-1:0]    w_idx,
  input  logic [SAMPLE_W-1:0] w_data,
  input  logic                ts_we,
  input  logic [TS_W-1:0]     ts_in,
  input  logic [SLOT_W-1:0]   r_slot,
  input  logic [IDX_W-1:0]    r_idx,
  output logic [SAMPLE_W-1:0] r_data,
  output logic [TS_W-1:0]     r_ts
);

  logic [SAMPLE_W-1:0] slot_word [NUM_SLOTS];
  logic [TS_W-1:0]     slot_ts   [NUM_SLOTS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [SAMPLE_W-1:0] bank [SEG_LEN];
    logic [TS_W-1:0]     ts_q;

    always_ff @(posedge clk) begin
      if (we && (w_slot == SLOT_W'(s))) bank[w_idx] <= w_data;
      if (ts_we && (w_slot == SLOT_W'(s))) ts_q <= ts_in;
    end

    assign slot_word[s] = bank[r_idx];
    assign slot_ts[s]   = ts_q;
  end

  assign r_data = slot_word[r_slot];
  assign r_ts   = slot_ts[r_slot];

endmodule

// File: rtl/seg_rd_ctrl.sv
module seg_rd_ctrl #(
  parameter int SEG_LEN   = 32,
  parameter int NUM_SLOTS = 4,
  localparam int IDX_W    = $clog2(SEG_LEN),
  localparam int SLOT_W   = $clog2(NUM_SLOTS),
  localparam int PTR_W    = SLOT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PTR_W-1:0]  wptr,
  input  logic              out_ready,
  output logic [PTR_W-1:0]  rptr,
  output logic [SLOT_W-1:0] r_slot,
  output logic [IDX_W-1:0]  r_idx,
  output logic              out_valid,
  output logic              out_last,
  output logic              data_avail
);

  logic fire;

  assign data_avail = (wptr != rptr);
  assign out_valid  = data_avail;
  assign out_last   = (r_idx == IDX_W'(SEG_LEN - 1));
  assign r_slot     = rptr[SLOT_W-1:0];
  assign fire       = out_valid && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      r_idx <= '0;
    end else if (fire) begin
      if (out_last) begin
        r_idx <= '0;
        rptr  <= rptr + PTR_W'(1);
      end else begin
        r_idx <= r_idx + IDX_W'(1);
      end
    end
  end

  // R7: a slot is released only after its final word was taken
  a_r7_release_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr != $past(rptr)) |-> $past(out_last && out_ready));

endmodule

// File: rtl/seg_capture.sv
module seg_capture #(
  parameter int SAMPLE_W  = 12,
  parameter int TS_W      = 16,
  parameter int SEG_LEN   = 32,
  parameter int NUM_SLOTS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_data,
  input  logic                trig,
  input  logic                out_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  output logic [TS_W-1:0]     out_ts,
  output logic                out_last,
  output logic                data_avail,
  output logic                overflow
);

  localparam int IDX_W  = $clog2(SEG_LEN);
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int PTR_W  = SLOT_W + 1;

  logic [TS_W-1:0]   ts_now;
  logic [PTR_W-1:0]  wptr, rptr;
  logic              we, ts_we;
  logic [SLOT_W-1:0] w_slot, r_slot;
  logic [IDX_W-1:0]  w_idx, r_idx;

  seg_coarse_ctr #(.TS_W(TS_W)) u_ctr (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  seg_wr_ctrl #(.SEG_LEN(SEG_LEN), .NUM_SLOTS(NUM_SLOTS)) u_wr (
    .clk(clk), .rst_n(rst_n), .trig(trig), .smp_valid(smp_valid),
    .rptr(rptr), .wptr(wptr), .we(we), .w_slot(w_slot), .w_idx(w_idx),
    .ts_we(ts_we), .overflow(overflow)
  );

  seg_store #(.SAMPLE_W(SAMPLE_W), .TS_W(TS_W), .SEG_LEN(SEG_LEN),
              .NUM_SLOTS(NUM_SLOTS)) u_store (
    .clk(clk), .we(we), .w_slot(w_slot), .w_idx(w_idx), .w_data(smp_data),
    .ts_we(ts_we), .ts_in(ts_now), .r_slot(r_slot), .r_idx(r_idx),
    .r_data(out_data), .r_ts(out_ts)
  );

  seg_rd_ctrl #(.SEG_LEN(SEG_LEN), .NUM_SLOTS(NUM_SLOTS)) u_rd (
    .clk(clk), .rst_n(rst_n), .wptr(wptr), .out_ready(out_ready),
    .rptr(rptr), .r_slot(r_slot), .r_idx(r_idx), .out_valid(out_valid),
    .out_last(out_last), .data_avail(data_avail)
  );

  // R5: the two pointers never drift more than one full lap apart
  a_r5_ptr_gap: assert property (@(posedge clk) disable iff (!rst_n)
    (PTR_W'(wptr - rptr) <= PTR_W'(NUM_SLOTS)));

  // R9: a stalled word is held intact
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                   $stable(out_ts) && $stable(out_last)));

endmodule

// File: tb/seg_capture_bench.sv
module seg_capture_bench;

  localparam int SW = 12;
  localparam int TW = 8;
  localparam int SL = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          smp_valid = 1'b0;
  logic [SW-1:0] smp_data = '0;
  logic          trig = 1'b0;
  logic          out_ready = 1'b0;
  logic          out_valid, out_last, data_avail, overflow;
  logic [SW-1:0] out_data;
  logic [TW-1:0] out_ts;

  seg_capture #(.SAMPLE_W(SW), .TS_W(TW), .SEG_LEN(SL), .NUM_SLOTS(4)) u_seg_capture (
    .clk(clk), .rst_n(rst_n), .smp_valid(smp_valid), .smp_data(smp_data),
    .trig(trig), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_ts(out_ts), .out_last(out_last),
    .data_avail(data_avail), .overflow(overflow)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0;
  int fails  = 0;
  int bcnt;              // bench copy of the time base (R3)
  int nseg   = 0;        // segments triggered and expected
  int rd_seg = 0;
  int rd_idx = 0;
  int rd_mode = 2;       // 0 always ready, 1 alternate, 2 stalled
  int cyc    = 0;
  bit done   = 1'b0;
  logic [TW-1:0] exp_ts [64];

  function automatic logic [SW-1:0] smp_of(int s, int i);
    return SW'((s * 97 + i * 13 + 5) % 4096);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n)
    if (!rst_n) bcnt <= 0;
    else        bcnt <= bcnt + 1;

  // Reader: decides ready at the negedge and checks the word it commits to
  always @(negedge clk) begin
    if (rst_n) begin
      logic r;
      case (rd_mode)
        0:       r = 1'b1;
        1:       r = ~out_ready;
        default: r = 1'b0;
      endcase
      out_ready = r;
      if (out_valid && r) begin
        if (rd_seg >= nseg) begin
          chk(1'b0, "R5 R8 unexpected segment word", rd_seg, nseg);
        end else begin
          chk(out_data == smp_of(rd_seg, rd_idx), "R2 R9 sample word",
              int'(out_data), int'(smp_of(rd_seg, rd_idx)));
          if (rd_idx == 0)
            chk(out_ts == exp_ts[rd_seg], "R3 timestamp", int'(out_ts), int'(exp_ts[rd_seg]));
          if (rd_idx == SL - 1 || rd_idx == SL - 2)
            chk(out_last == (rd_idx == SL - 1), "R7 last marker", int'(out_last),
                int'(rd_idx == SL - 1));
          rd_idx++;
          if (rd_idx == SL) begin rd_idx = 0; rd_seg++; end
        end
      end
    end
  end

  task automatic idle();
    @(negedge clk);
    trig = 1'b0; smp_valid = 1'b0;
  endtask

  // One capture: gap idle cycles before each odd index; optional retrigger
  task automatic write_seg(input int gap, input bit retrig);
    int id;
    @(negedge clk);
    id = nseg;
    exp_ts[id] = TW'(bcnt);
    nseg = nseg + 1;
    trig = 1'b1; smp_valid = 1'b1; smp_data = smp_of(id, 0);
    for (int i = 1; i < SL; i++) begin
      if (i % 2 == 1)
        for (int g = 0; g < gap; g++) begin
          @(negedge clk); trig = 1'b0; smp_valid = 1'b0; smp_data = 12'hFFF;
        end
      @(negedge clk);
      smp_valid = 1'b1; smp_data = smp_of(id, i);
      trig = retrig && (i == 10 || i == SL - 1);  // R4: mid-capture triggers
    end
  endtask

  task automatic wait_drained();
    while (rd_seg < nseg) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      chk(1'b0, "watchdog expired", cyc, 100000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0,  "R1 out_valid after reset",  out_valid, 0);
    chk(data_avail == 1'b0, "R1 data_avail after reset", data_avail, 0);
    chk(overflow == 1'b0,   "R1 overflow after reset",   overflow, 0);

    // Phase A: reader stalled, fill all slots
    rd_mode = 2;
    write_seg(0, 1'b1);
    chk(data_avail == 1'b0, "R6 not yet available before last edge", data_avail, 0);
    idle();
    chk(data_avail == 1'b1, "R6 available after last sample", data_avail, 1);
    chk(overflow == 1'b0,   "R4 retrigger leaves overflow clear", overflow, 0);
    write_seg(1, 1'b0); idle();
    write_seg(2, 1'b1); idle();
    write_seg(3, 1'b0); idle();
    chk(overflow == 1'b0, "R5 no overflow at exactly full", overflow, 0);

    // Dropped trigger while full
    @(negedge clk);
    trig = 1'b1; smp_valid = 1'b1; smp_data = 12'hABC;
    @(negedge clk);
    trig = 1'b0;
    chk(overflow == 1'b1, "R5 overflow set by trigger on full", overflow, 1);
    repeat (31) @(negedge clk);
    idle();

    // Phase B: throttled reading overlapped with new captures
    rd_mode = 1;
    while (rd_seg < 1) @(negedge clk);
    write_seg(0, 1'b0); idle();
    while (rd_seg < 2) @(negedge clk);
    write_seg(1, 1'b1); idle();
    wait_drained();
    @(negedge clk);
    chk(data_avail == 1'b0, "R6 data_avail low when drained", data_avail, 0);
    chk(out_valid == 1'b0,  "R7 out_valid low when drained", out_valid, 0);
    chk(overflow == 1'b1,   "R5 overflow stays sticky", overflow, 1);

    // Phase C: back-to-back triggers, free reader, across counter wrap
    rd_mode = 0;
    while ((bcnt % 256) != 250) @(negedge clk);
    write_seg(0, 1'b0);
    write_seg(0, 1'b0);
    write_seg(2, 1'b1);
    idle();
    wait_drained();
    // Sweep of gap patterns with concurrent reading
    for (int g = 0; g < 4; g++) begin
      write_seg(g, g[0]);
      idle();
    end
    wait_drained();
    repeat (4) @(negedge clk);
    chk(rd_seg == nseg, "R8 every triggered segment read in order", rd_seg, nseg);
    chk(data_avail == 1'b0, "R6 final data_avail", data_avail, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule